// File: doc/BRIEF.md
# Quad-Line Serial Flash Program and Erase Sequencer

This block sits on the host side of a serial NOR flash that carries all traffic on four data lines. A local client hands it one request at a time. A request names an operation (page program, small-region erase, large-region erase or whole-device erase), a 24-bit byte address and, for a program, a byte count. For a program, the data bytes then arrive on a valid/ready stream. The sequencer opens a one-byte write-enable transaction and closes it again. It then sends the command transaction. After that it reads the flash status byte in repeated short transactions until the busy flag clears. It ends by pulsing `done`, or `err` with a reason code.

Every byte on the bus takes two serial-clock periods, high nibble first. The flash samples on the rising edge of `spi_sclk`. While the status byte is read, the host releases the data lines. A program that is empty, longer than one 256-byte page, or runs past the end of its page is refused at once, and the bus is not touched. The client has to know that programming can only clear bits. The sequencer never reads back or merges data.

Back-pressure rules: `req_ready` is high only while the sequencer is idle, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. `wr_ready` is high only when the sequencer can put the next data byte on the bus. A byte moves on an edge where `wr_valid` and `wr_ready` are both high. The client may hold `wr_valid` low for any number of cycles, and the bus then waits with chip select held low. Exactly `req_len` bytes are taken per accepted program.

Top module: `qspi_pe_seq`

## Requirements
- R1: A page-program request (op code 0) with length 0, length above 256, or (address bits [7:0] + length) above 256 is refused. `err` pulses with `err_code` = 1, `done` stays low and `spi_cs_n` stays high throughout.
- R2: Every accepted operation starts with a transaction that carries the single byte 0x06, and chip select goes high after it before the command transaction begins.
- R3: A page program (op 0) sends 0x02, then address bits [23:16], [15:8] and [7:0], then the data bytes in stream order, all inside one chip-select low period.
- R4: A small-region erase (op 1) sends 0x20 and a large-region erase (op 2) sends 0xD8, each followed by the three address bytes, most significant byte first. A whole-device erase (op 3) sends 0xC7 alone.
- R5: Each byte is sent on `spi_dq_o[3:0]` as two nibbles, high nibble first, one nibble per `spi_sclk` period. The data lines hold their value while `spi_sclk` is high, and `spi_sclk` is low whenever `spi_cs_n` is high.
- R6: Each status poll is its own transaction: the byte 0x05 is driven, and then one byte is read over exactly two more `spi_sclk` periods with `spi_dq_oe` low, giving four rising edges in all.
- R7: Bit 0 of the status byte is the busy flag, and the other bits are ignored. When a poll reads bit 0 = 0, `done` pulses for one cycle with `err_code` = 0. So an operation during which the flash reports busy K times makes K+1 polls. `done` and `err` are never high together.
- R8: If `poll_limit` polls in a row read busy, the sequencer stops polling, pulses `err` with `err_code` = 2 and does not pulse `done`.
- R9: `wr_ready` is high only inside the command transaction of a program, once the address has been sent. A byte held on `wr_data` through a stall is the byte that is sent.
- R10: `req_ready` is high exactly when idle. It is already high in the cycle in which `done` pulses, so a request held waiting is taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request taken |
| req_op | input | 2 | 0 program, 1 small erase, 2 large erase, 3 whole erase |
| req_addr | input | 24 | Byte address |
| req_len | input | 9 | Program byte count (1..256) |
| wr_valid | input | 1 | Data byte offered |
| wr_ready | output | 1 | Data byte taken |
| wr_data | input | 8 | Program data byte |
| poll_limit | input | 16 | Busy polls allowed before timeout |
| done | output | 1 | One-cycle success pulse |
| err | output | 1 | One-cycle error pulse |
| err_code | output | 2 | 0 none, 1 refused range, 2 poll timeout |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_dq_o | output | 4 | Data lines out |
| spi_dq_oe | output | 1 | Data line drive enable |
| spi_dq_i | input | 4 | Data lines in |

## Verification
The completion pulse of one operation and the acceptance of the next request can fall in the same cycle, because the sequencer is already idle while `done` is high. The bench provokes this by holding a second request valid while the first one is still polling. At each falling clock edge it records whether `done`, `req_valid` and `req_ready` are all high together. It then requires exactly one such cycle, two completions, and the bus traffic of both operations in order. Data-stream stalls that land while the nibble engine is still busy are provoked by periodic gaps in `wr_valid`, and they are judged by comparing the bytes captured at the flash side with the expected data.

// File: rtl/qspi_pe_pkg.sv
package qspi_pe_pkg;
  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SUB  = 2'd1,
    OP_SEC  = 2'd2,
    OP_BULK = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WEN, ST_GAP_A, ST_CMD, ST_GAP_B, ST_POLL, ST_GAP_C
  } st_e;

  localparam logic [7:0] CMD_WEN   = 8'h06;
  localparam logic [7:0] CMD_PROG  = 8'h02;
  localparam logic [7:0] CMD_SUB   = 8'h20;
  localparam logic [7:0] CMD_SEC   = 8'hD8;
  localparam logic [7:0] CMD_BULK  = 8'hC7;
  localparam logic [7:0] CMD_RSTAT = 8'h05;

  function automatic logic [7:0] op_code(op_e op);
    case (op)
      OP_PROG: return CMD_PROG;
      OP_SUB:  return CMD_SUB;
      OP_SEC:  return CMD_SEC;
      default: return CMD_BULK;
    endcase
  endfunction
endpackage

// File: rtl/qspi_nibble_phy.sv
module qspi_nibble_phy (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       rd,
  input  logic [7:0] tx_byte,
  output logic       active,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       sclk,
  output logic [3:0] dq_o,
  output logic       dq_oe,
  input  logic [3:0] dq_i
);
  logic [1:0] cnt;
  logic [7:0] sh;
  logic       rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      done    <= 1'b0;
      cnt     <= '0;
      sh      <= '0;
      rd_q    <= 1'b0;
      rx_byte <= '0;
    end else begin
      done <= 1'b0;
      if (!active && start) begin
        active <= 1'b1;
        cnt    <= '0;
        sh     <= tx_byte;
        rd_q   <= rd;
      end else if (active) begin
        cnt <= cnt + 2'd1;
        if (cnt == 2'd1) begin
          sh <= {sh[3:0], 4'h0};
          if (rd_q) rx_byte[7:4] <= dq_i;
        end
        if (cnt == 2'd3) begin
          active <= 1'b0;
          done   <= 1'b1;
          if (rd_q) rx_byte[3:0] <= dq_i;
        end
      end
    end
  end

  assign sclk  = active & cnt[0];
  assign dq_o  = active ? sh[7:4] : 4'h0;
  assign dq_oe = active & ~rd_q;

  // R5: lines hold while the flash samples
  assert_dq_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cnt == 2'd1) |-> $stable(dq_o));
endmodule

// File: rtl/qspi_poll_guard.sv
module qspi_poll_guard #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          busy_seen,
  input  logic [CW-1:0] limit,
  output logic          expired
);
  logic [CW-1:0] cnt;
  logic [CW:0]   next_cnt;

  assign next_cnt = {1'b0, cnt} + {{CW{1'b0}}, 1'b1};
  assign expired  = busy_seen && (next_cnt >= {1'b0, limit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (clr)                 cnt <= '0;
    else if (busy_seen && !expired) cnt <= next_cnt[CW-1:0];
  end
endmodule

// File: rtl/qspi_pe_seq.sv
module qspi_pe_seq
  import qspi_pe_pkg::*;
#(
  parameter int PAGE_BYTES = 256,
  parameter int TO_W       = 16,
  parameter logic [7:0] STAT_BUSY_MASK = 8'h01,
  localparam int PAGE_W = $clog2(PAGE_BYTES),
  localparam int LEN_W  = PAGE_W + 1,
  localparam int IDX_W  = LEN_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [23:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  input  logic [TO_W-1:0]  poll_limit,
  output logic             done,
  output logic             err,
  output logic [1:0]       err_code,
  output logic             spi_cs_n,
  output logic             spi_sclk,
  output logic [3:0]       spi_dq_o,
  output logic             spi_dq_oe,
  input  logic [3:0]       spi_dq_i
);
  st_e              st;
  op_e              op_q;
  logic [23:0]      addr_q;
  logic [LEN_W-1:0] len_q;
  logic [IDX_W-1:0] idx, last_idx;
  logic             phy_start, phy_active, phy_done, phy_rd, phy_free;
  logic [7:0]       phy_tx, phy_rx;
  logic             need_data, stat_busy, busy_seen, expired, range_bad;
  logic [LEN_W:0]   end_off;

  assign end_off   = {1'b0, {(LEN_W-PAGE_W){1'b0}}, req_addr[PAGE_W-1:0]} + {1'b0, req_len};
  assign range_bad = (op_e'(req_op) == OP_PROG) &&
                     (req_len == '0 || end_off > (LEN_W+1)'(PAGE_BYTES));

  assign last_idx  = ((op_q == OP_BULK) ? IDX_W'(0) : IDX_W'(3)) +
                     ((op_q == OP_PROG) ? IDX_W'(len_q) : IDX_W'(0));
  assign need_data = (st == ST_CMD) && (op_q == OP_PROG) && (idx >= IDX_W'(4));
  assign phy_free  = !phy_active && !phy_done;
  assign wr_ready  = need_data && phy_free;
  assign phy_start = phy_free && ((st == ST_WEN) || (st == ST_POLL) ||
                     ((st == ST_CMD) && (!need_data || wr_valid)));
  assign phy_rd    = (st == ST_POLL) && (idx == IDX_W'(1));

  always_comb begin
    phy_tx = CMD_RSTAT;
    if (st == ST_WEN) phy_tx = CMD_WEN;
    else if (st == ST_CMD) begin
      case (idx)
        IDX_W'(0): phy_tx = op_code(op_q);
        IDX_W'(1): phy_tx = addr_q[23:16];
        IDX_W'(2): phy_tx = addr_q[15:8];
        IDX_W'(3): phy_tx = addr_q[7:0];
        default:   phy_tx = wr_data;
      endcase
    end
  end

  assign stat_busy = (phy_rx & STAT_BUSY_MASK) != 8'h00;
  assign busy_seen = (st == ST_POLL) && (idx == IDX_W'(1)) && phy_done && stat_busy;
  assign req_ready = (st == ST_IDLE);
  assign spi_cs_n  = (st == ST_IDLE) || (st == ST_GAP_A) || (st == ST_GAP_B) || (st == ST_GAP_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      op_q     <= OP_PROG;
      addr_q   <= '0;
      len_q    <= '0;
      idx      <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
      err_code <= 2'd0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      unique case (st)
        ST_IDLE: if (req_valid) begin
          if (range_bad) begin
            err      <= 1'b1;
            err_code <= 2'd1;
          end else begin
            st       <= ST_WEN;
            op_q     <= op_e'(req_op);
            addr_q   <= req_addr;
            len_q    <= req_len;
            idx      <= '0;
            err_code <= 2'd0;
          end
        end
        ST_WEN:   if (phy_done) st <= ST_GAP_A;
        ST_GAP_A: st <= ST_CMD;
        ST_CMD: if (phy_done) begin
          if (idx == last_idx) begin
            st  <= ST_GAP_B;
            idx <= '0;
          end else idx <= idx + IDX_W'(1);
        end
        ST_GAP_B: st <= ST_POLL;
        ST_POLL: if (phy_done) begin
          if (idx == '0) idx <= IDX_W'(1);
          else begin
            idx <= '0;
            if (!stat_busy) begin
              st   <= ST_IDLE;
              done <= 1'b1;
            end else if (expired) begin
              st       <= ST_IDLE;
              err      <= 1'b1;
              err_code <= 2'd2;
            end else st <= ST_GAP_C;
          end
        end
        ST_GAP_C: st <= ST_POLL;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  qspi_nibble_phy i_phy (
    .clk(clk), .rst_n(rst_n), .start(phy_start), .rd(phy_rd), .tx_byte(phy_tx),
    .active(phy_active), .done(phy_done), .rx_byte(phy_rx), .sclk(spi_sclk),
    .dq_o(spi_dq_o), .dq_oe(spi_dq_oe), .dq_i(spi_dq_i)
  );

  qspi_poll_guard #(.CW(TO_W)) i_guard (
    .clk(clk), .rst_n(rst_n), .clr(st == ST_IDLE), .busy_seen(busy_seen),
    .limit(poll_limit), .expired(expired)
  );

  // R1: refused request leaves the bus quiet and flags range error
  assert_reject_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && req_valid && range_bad) |=> (err && spi_cs_n && err_code == 2'd1));
  // R5: no clock while deselected
  assert_sclk_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);
  // R6: lines released during the status byte
  assert_poll_listen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_POLL && idx == IDX_W'(1) && phy_active) |-> !spi_dq_oe);
  // R7: completion and error pulses exclusive
  assert_pulse_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));
  // R9: data only taken inside a live transaction
  assert_wr_live_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (!spi_cs_n && !req_ready));
endmodule

// File: tb/test_qspi_pe_seq.sv
module test_qspi_pe_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, wr_valid = 1'b0, wr_ready;
  logic [1:0] req_op = 2'd0;
  logic [23:0] req_addr = '0;
  logic [8:0] req_len = '0;
  logic [7:0] wr_data = '0;
  logic [15:0] poll_limit = 16'd1000;
  logic done, err, spi_cs_n, spi_sclk, spi_dq_oe;
  logic [1:0] err_code;
  logic [3:0] spi_dq_o, spi_dq_i;

  always #10 clk = ~clk;

  qspi_pe_seq i_qspi_pe_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_len(req_len), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .poll_limit(poll_limit), .done(done),
    .err(err), .err_code(err_code), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
    .spi_dq_o(spi_dq_o), .spi_dq_oe(spi_dq_oe), .spi_dq_i(spi_dq_i)
  );

  // flash-side model
  logic [7:0] tbytes [0:7][0:263];
  int tlen [0:7];
  logic [7:0] cur [0:263];
  int cur_n = 0, nib = 0, rises = 0, falls = 0;
  int tcount = 0, pcount = 0, poll_bad = 0;
  int p_base = 0, busy_target = 0;
  logic [3:0] hi_nib = 4'h0;
  logic [7:0] stat;

  assign stat = {4'hA, 3'b010, ((pcount - p_base) < busy_target)};
  assign spi_dq_i = (falls == 2) ? stat[7:4] : stat[3:0];

  always @(negedge spi_cs_n) begin cur_n = 0; nib = 0; rises = 0; falls = 0; end
  always @(negedge spi_sclk) falls++;
  always @(posedge spi_sclk) begin
    rises++;
    if (spi_dq_oe) begin
      if (nib % 2 == 0) hi_nib = spi_dq_o;
      else begin
        if (cur_n < 264) cur[cur_n] = {hi_nib, spi_dq_o};
        cur_n++;
      end
      nib++;
    end
  end
  always @(posedge spi_cs_n) begin
    if (cur_n > 0 || rises > 0) begin
      if (cur_n >= 1 && cur[0] == 8'h05) begin
        if (cur_n != 1 || rises != 4) poll_bad++;
        pcount++;
      end else begin
        for (int k = 0; k < 264; k++) tbytes[tcount % 8][k] = cur[k];
        tlen[tcount % 8] = cur_n;
        tcount++;
      end
    end
  end

  int n_done = 0, n_err = 0, coincide = 0;
  always @(negedge clk) begin
    if (done) n_done++;
    if (err) n_err++;
    if (done && req_valid && req_ready) coincide++;
  end

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int addr, input int i);
    return 8'((addr + i * 13 + 5) & 255);
  endfunction

  function automatic logic [7:0] exp_code(input int op);
    case (op)
      0: return 8'h02;
      1: return 8'h20;
      2: return 8'hD8;
      default: return 8'hC7;
    endcase
  endfunction

  // kind: 0 success, 1 refused, 2 timeout
  task automatic run_op(input int op, input int addr, input int len,
                        input int busy, input int limit, input int kind);
    int t0, p0, d0, e0, w, n, mism, ti;
    t0 = tcount; p0 = pcount; d0 = n_done; e0 = n_err;
    p_base = pcount; busy_target = busy; poll_limit = 16'(limit);
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'(op); req_addr = 24'(addr); req_len = 9'(len);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == (kind == 1), "R10 ready after accept", int'(req_ready), int'(kind == 1));
    if (kind != 1 && op == 0) begin
      for (int i = 0; i < len; i++) begin
        if (i % 5 == 2) begin wr_valid = 1'b0; @(negedge clk); end
        wr_valid = 1'b1; wr_data = pat(addr, i);
        while (!wr_ready) @(negedge clk);
        @(negedge clk);
      end
      wr_valid = 1'b0;
    end
    w = 0;
    while (n_done == d0 && n_err == e0 && w < 20000) begin @(negedge clk); w++; end
    repeat (3) @(negedge clk);
    if (kind == 1) begin
      chk(tcount == t0 && pcount == p0, "R1 bus untouched", tcount - t0 + pcount - p0, 0);
      chk(n_err - e0 == 1 && n_done == d0 && err_code == 2'd1, "R1 error code",
          int'(err_code), 1);
    end else begin
      chk(tcount - t0 == 2, "R2 transaction count", tcount - t0, 2);
      ti = t0 % 8;
      chk(tlen[ti] == 1 && tbytes[ti][0] == 8'h06, "R2 write enable", int'(tbytes[ti][0]), 6);
      ti = (t0 + 1) % 8;
      n = (op == 3 ? 1 : 4) + (op == 0 ? len : 0);
      chk(tlen[ti] == n, op == 0 ? "R3 command length" : "R4 command length", tlen[ti], n);
      mism = 0;
      if (tbytes[ti][0] != exp_code(op)) mism++;
      if (op != 3) begin
        if (tbytes[ti][1] != 8'(addr >> 16)) mism++;
        if (tbytes[ti][2] != 8'(addr >> 8)) mism++;
        if (tbytes[ti][3] != 8'(addr)) mism++;
      end
      if (op == 0) for (int i = 0; i < len; i++) if (tbytes[ti][4 + i] != pat(addr, i)) mism++;
      chk(mism == 0, op == 0 ? "R3 R5 R9 bytes" : "R4 R5 bytes", mism, 0);
      chk(poll_bad == 0, "R6 poll shape", poll_bad, 0);
      if (kind == 0) begin
        chk(pcount - p0 == busy + 1, "R7 poll count", pcount - p0, busy + 1);
        chk(n_done - d0 == 1 && n_err == e0 && err_code == 2'd0, "R7 done", n_done - d0, 1);
      end else begin
        chk(pcount - p0 == limit, "R8 poll count", pcount - p0, limit);
        chk(n_err - e0 == 1 && n_done == d0 && err_code == 2'd2, "R8 timeout code",
            int'(err_code), 2);
      end
    end
  endtask

  int offs [0:3] = '{0, 16, 240, 255};
  int lens [0:6] = '{1, 2, 16, 17, 256, 0, 257};

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(spi_cs_n && !spi_sclk && req_ready && !done && !err && !wr_ready && err_code == 0,
        "R10 reset state", int'(spi_cs_n), 1);
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 7; b++) begin
        int ad, bad;
        ad = 24'h120000 + a * 24'h000101 + offs[a];
        ad = (ad & 24'hFFFF00) | offs[a];
        bad = (lens[b] == 0 || lens[b] > 256 || offs[a] + lens[b] > 256);
        run_op(0, ad, lens[b], (a + b) % 3, 1000, bad ? 1 : 0);
      end
    for (int op = 1; op < 4; op++)
      for (int k = 0; k < 3; k++)
        run_op(op, 24'hA5C300 + op * 24'h010203 + k, 1, (k == 2) ? 5 : k, 1000, 0);
    run_op(3, 0, 1, 10, 4, 2);
    run_op(2, 24'h00F000, 1, 4, 4, 2);
    run_op(1, 24'h003000, 1, 3, 4, 0);
    run_op(0, 24'h4400C0, 64, 1, 1, 2);
    // back-to-back: next request waiting when previous completes
    begin
      int t0, d0, c0, w;
      t0 = tcount; d0 = n_done; c0 = coincide;
      p_base = pcount; busy_target = 2; poll_limit = 16'd1000;
      @(negedge clk);
      req_valid = 1'b1; req_op = 2'd2; req_addr = 24'h778899; req_len = 9'd1;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_op = 2'd1; req_addr = 24'h112233;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      w = 0;
      while (n_done - d0 < 2 && w < 20000) begin @(negedge clk); w++; end
      repeat (3) @(negedge clk);
      chk(coincide - c0 == 1, "R10 accept in done cycle", coincide - c0, 1);
      chk(n_done - d0 == 2 && tcount - t0 == 4, "R10 both completed", tcount - t0, 4);
      chk(tbytes[(t0 + 3) % 8][0] == 8'h20 && tbytes[(t0 + 3) % 8][3] == 8'h33,
          "R4 second command", int'(tbytes[(t0 + 3) % 8][0]), 32);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule